// File: doc/BRIEF.md
# Per-Line Rise/Fall Delayed Output Bank

This block drives a bank of output lines, each of which follows a requested logical level only after a delay that the line holds for itself. Every line stores two delays in microseconds, one applied when the request goes from 0 to 1 and one applied when it goes from 1 to 0. It also stores a polarity bit that inverts the pin level relative to the logical level. A shared prescaler turns the system clock into a 1 µs tick, and the per-line countdowns advance only on that tick. The block is used to sequence enables and resets whose consumers need a defined settle time after each edge.

The request vector is a plain level input, with no handshake. It is sampled on every clock. The configuration port is a plain one-cycle write strobe carrying a line index, both delays and the polarity bit. There is no back-pressure: a write is accepted in the cycle it is presented. A pending transition keeps the delay that was loaded when it started, so a later configuration write takes effect from the next transition onwards.

Top module: `rfdly_bank`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, every pin is 0, every busy flag is 0 and every logical level is 0. Delays and polarity reset to 0.
- R2: A clock edge with cfg_we high and cfg_idx below LINES stores cfg_rise, cfg_fall and cfg_inv into line cfg_idx. An index of LINES or above changes no line.
- R3: When a line's request is 1 while its logical level is 0, and the line is idle with a non-zero rise delay D, the line loads D and turns busy. Its logical level becomes 1 at the edge of the D-th microsecond tick after the loading edge.
- R4: A 1-to-0 request on a line applies the fall delay in the same way as R3.
- R5: When the request equals the logical level at an edge, any pending transition on that line is cancelled and busy is 0 after that edge. The logical level does not change.
- R6: After a cancelled transition, a new differing request reloads the full delay for its direction and starts the count afresh.
- R7: If the delay for the direction of the change is 0, the logical level takes the request value at the very edge that samples the change, and busy stays 0.
- R8: pin[i] equals the logical level of line i XOR its stored polarity bit. A polarity write changes the pin from the next cycle without altering the logical level.
- R9: busy[i] is 1 exactly while line i has a pending transition. A logical level changes during a pending transition only at an edge where the tick is high.
- R10: The tick is high on one clock edge in every CYC_PER_US edges. The first tick after reset release is on the CYC_PER_US-th edge.
- R11: Lines are independent: requests and configuration on one line do not affect the timing or level of another.
- R12: Delays up to 2^DLY_W-1 are held without truncation. A rise delay of 70000 µs, which needs 17 bits, is counted in full.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req | input | LINES | Requested logical level per line |
| cfg_we | input | 1 | Configuration write strobe, one cycle per write |
| cfg_idx | input | IDX_W | Line index of the write |
| cfg_rise | input | DLY_W | Rise delay in microseconds |
| cfg_fall | input | DLY_W | Fall delay in microseconds |
| cfg_inv | input | 1 | Polarity: 1 makes the pin the inverse of the logical level |
| pin | output | LINES | Delayed pin level per line |
| busy | output | LINES | Pending-transition flag per line |

## Verification
On every cycle the assertions check four things. A logical level only ever moves toward the previously sampled request. A pending line changes level only on a tick edge. A line whose request matched its level is never busy afterwards. The tick never fires on two edges in a row. Only the bench's scenarios can show the actual countdown lengths, the cancel-and-restart sequence, zero-delay pass-through, polarity inversion, the ignored out-of-range write and the full 17-bit delay. The bench measures these as cycle windows and also compares every cycle against a per-line reference model.

// File: rtl/rfdly_pkg.sv
package rfdly_pkg;
  typedef enum logic {
    LN_IDLE = 1'b0,
    LN_WAIT = 1'b1
  } ln_state_t;
endpackage

// File: rtl/rfdly_tick.sv
module rfdly_tick #(
  parameter int CYC_PER_US = 100
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  generate
    if (CYC_PER_US <= 1) begin : g_every
      assign tick = 1'b1;
    end else begin : g_count
      localparam int PW = $clog2(CYC_PER_US);
      localparam logic [PW-1:0] LAST = PW'(CYC_PER_US - 1);
      logic [PW-1:0] pc_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else if (pc_q == LAST) pc_q <= '0;
        else pc_q <= pc_q + 1'b1;
      end
      assign tick = (pc_q == LAST);
    end
  endgenerate
endmodule

// File: rtl/rfdly_line.sv
module rfdly_line
  import rfdly_pkg::*;
#(
  parameter int DLY_W = 18
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             req,
  input  logic             wr,
  input  logic [DLY_W-1:0] wr_rise,
  input  logic [DLY_W-1:0] wr_fall,
  input  logic             wr_inv,
  output logic             lvl,
  output logic             pin,
  output logic             busy
);
  logic [DLY_W-1:0] rise_q, fall_q, cnt_q, dly;
  logic             inv_q;
  ln_state_t        st_q;

  assign dly = req ? rise_q : fall_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rise_q <= '0;
      fall_q <= '0;
      inv_q  <= 1'b0;
    end else if (wr) begin
      rise_q <= wr_rise;
      fall_q <= wr_fall;
      inv_q  <= wr_inv;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= LN_IDLE;
      cnt_q <= '0;
      lvl   <= 1'b0;
    end else if (req == lvl) begin
      st_q <= LN_IDLE;
    end else if (st_q == LN_IDLE) begin
      if (dly == '0) begin
        lvl <= req;
      end else begin
        st_q  <= LN_WAIT;
        cnt_q <= dly;
      end
    end else if (tick) begin
      if (cnt_q == DLY_W'(1)) begin
        lvl  <= req;
        st_q <= LN_IDLE;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign pin  = lvl ^ inv_q;
  assign busy = (st_q == LN_WAIT);
endmodule

// File: rtl/rfdly_bank.sv
module rfdly_bank #(
  parameter int LINES      = 8,
  parameter int DLY_W      = 18,
  parameter int IDX_W      = 5,
  parameter int CYC_PER_US = 100
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [LINES-1:0] req,
  input  logic             cfg_we,
  input  logic [IDX_W-1:0] cfg_idx,
  input  logic [DLY_W-1:0] cfg_rise,
  input  logic [DLY_W-1:0] cfg_fall,
  input  logic             cfg_inv,
  output logic [LINES-1:0] pin,
  output logic [LINES-1:0] busy
);
  logic             tick;
  logic [LINES-1:0] lvl;

  rfdly_tick #(.CYC_PER_US(CYC_PER_US)) u_tick (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  generate
    for (genvar i = 0; i < LINES; i++) begin : g_line
      logic sel;
      assign sel = cfg_we && (32'(cfg_idx) == i);
      rfdly_line #(.DLY_W(DLY_W)) u_line (
        .clk(clk), .rst_n(rst_n), .tick(tick), .req(req[i]),
        .wr(sel), .wr_rise(cfg_rise), .wr_fall(cfg_fall), .wr_inv(cfg_inv),
        .lvl(lvl[i]), .pin(pin[i]), .busy(busy[i])
      );
    end
  endgenerate
endmodule

// File: rtl/rfdly_chk.sv
module rfdly_chk #(
  parameter int LINES      = 8,
  parameter int CYC_PER_US = 100
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tick,
  input logic [LINES-1:0] req,
  input logic [LINES-1:0] lvl,
  input logic [LINES-1:0] busy
);
  // R1
  reset_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (busy == '0 && lvl == '0));

  // R3 R4
  lvl_toward_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((lvl ^ $past(lvl)) & (lvl ^ $past(req))) == '0);

  // R9
  pending_moves_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (($past(busy) & (lvl ^ $past(lvl))) != '0) |-> $past(tick));

  // R5
  match_cancels_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (busy & ~($past(req) ^ $past(lvl))) == '0);

  generate
    if (CYC_PER_US > 1) begin : g_tk
      // R10
      tick_spaced_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick |=> !tick);
    end
  endgenerate
endmodule

bind rfdly_bank rfdly_chk #(.LINES(LINES), .CYC_PER_US(CYC_PER_US)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .req(req), .lvl(lvl), .busy(busy)
);

// File: tb/sim_rfdly_bank.sv
`timescale 1ns/1ps
module sim_rfdly_bank;
  localparam int LINES = 4;
  localparam int DLY_W = 18;
  localparam int IDX_W = 5;
  localparam int CYC   = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [LINES-1:0] req = '0;
  logic cfg_we = 1'b0;
  logic [IDX_W-1:0] cfg_idx = '0;
  logic [DLY_W-1:0] cfg_rise = '0, cfg_fall = '0;
  logic cfg_inv = 1'b0;
  logic [LINES-1:0] pin, busy;

  always #2.5 clk = ~clk;

  rfdly_bank #(.LINES(LINES), .DLY_W(DLY_W), .IDX_W(IDX_W), .CYC_PER_US(CYC)) u0 (
    .clk(clk), .rst_n(rst_n), .req(req), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
    .cfg_rise(cfg_rise), .cfg_fall(cfg_fall), .cfg_inv(cfg_inv),
    .pin(pin), .busy(busy)
  );

  int vecs = 0, bad = 0;
  string tag = "R1";

  // reference model built from the requirements
  int m_pc = 0;
  bit m_lvl [LINES];
  bit m_wait[LINES];
  int m_cnt [LINES];
  int m_rise[LINES];
  int m_fall[LINES];
  bit m_inv [LINES];

  always @(posedge clk) begin
    if (!rst_n) begin
      m_pc = 0;
      for (int i = 0; i < LINES; i++) begin
        m_lvl[i] = 0; m_wait[i] = 0; m_cnt[i] = 0;
        m_rise[i] = 0; m_fall[i] = 0; m_inv[i] = 0;
      end
    end else begin
      bit t;
      t = (m_pc == CYC - 1);
      m_pc = t ? 0 : m_pc + 1;
      for (int i = 0; i < LINES; i++) begin
        int d;
        d = req[i] ? m_rise[i] : m_fall[i];
        if (req[i] == m_lvl[i]) m_wait[i] = 0;
        else if (!m_wait[i]) begin
          if (d == 0) m_lvl[i] = req[i];
          else begin m_wait[i] = 1; m_cnt[i] = d; end
        end else if (t) begin
          if (m_cnt[i] == 1) begin m_lvl[i] = req[i]; m_wait[i] = 0; end
          else m_cnt[i]--;
        end
      end
      if (cfg_we && int'(cfg_idx) < LINES) begin
        m_rise[cfg_idx] = int'(cfg_rise);
        m_fall[cfg_idx] = int'(cfg_fall);
        m_inv[cfg_idx]  = cfg_inv;
      end
    end
  end

  function automatic logic [LINES-1:0] exp_pin();
    logic [LINES-1:0] v;
    for (int i = 0; i < LINES; i++) v[i] = m_lvl[i] ^ m_inv[i];
    return v;
  endfunction

  function automatic logic [LINES-1:0] exp_busy();
    logic [LINES-1:0] v;
    for (int i = 0; i < LINES; i++) v[i] = m_wait[i];
    return v;
  endfunction

  task automatic chk(string t, logic [LINES-1:0] act, logic [LINES-1:0] expv);
    vecs++;
    if (act !== expv) begin
      bad++;
      $display("FAIL %s: actual %b expected %b at %0t", t, act, expv, $time);
    end
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    if (rst_n) begin
      chk({tag, " pin"}, pin, exp_pin());
      chk({tag, " busy"}, busy, exp_busy());
    end
  endtask

  task automatic cfg(int idx, int r, int f, bit inv);
    cfg_we = 1'b1; cfg_idx = IDX_W'(idx);
    cfg_rise = DLY_W'(r); cfg_fall = DLY_W'(f); cfg_inv = inv;
    step();
    cfg_we = 1'b0;
  endtask

  task automatic wait_pin(int ln, bit lv, int lim, output int n);
    n = 0;
    do begin step(); n++; end while (pin[ln] !== lv && n < lim);
  endtask

  task automatic in_range(string t, int n, int lo, int hi);
    vecs++;
    if (n < lo || n > hi) begin
      bad++;
      $display("FAIL %s: actual %0d cycles expected %0d..%0d", t, n, lo, hi);
    end
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    bad++;
    $display("FAIL watchdog: actual hung expected done");
    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end

  initial begin
    int n;
    void'($urandom(32'h5eed1234));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    step();
    chk("R1 pin", pin, '0);
    chk("R1 busy", busy, '0);

    // R7 zero delay follows at once
    tag = "R7";
    req = 4'b0101;
    step();
    chk("R7 pin", pin, 4'b0101);
    chk("R7 busy", busy, '0);

    // R8 polarity on line 1
    tag = "R8";
    cfg(1, 0, 0, 1);
    chk("R8 pin", pin, 4'b0111);
    req = '0;
    step(); step();
    chk("R8 pin low req", pin, 4'b0010);

    // R10 one microsecond delay
    tag = "R10";
    cfg(0, 1, 1, 0);
    req[0] = 1'b1;
    wait_pin(0, 1'b1, 20, n);
    in_range("R10 latency", n, 2, 3);
    req[0] = 1'b0;
    wait_pin(0, 1'b0, 20, n);

    // R3 rise delay 3, R9 busy while pending
    tag = "R3";
    cfg(0, 3, 2, 0);
    req[0] = 1'b1;
    step();
    chk("R9 busy", busy, 4'b0001);
    n = 1;
    while (pin[0] !== 1'b1 && n < 40) begin step(); n++; end
    in_range("R3 latency", n, 6, 7);

    // R4 fall delay 2
    tag = "R4";
    req[0] = 1'b0;
    wait_pin(0, 1'b0, 40, n);
    in_range("R4 latency", n, 4, 5);

    // R5 cancel
    tag = "R5";
    req[0] = 1'b1;
    step(); step();
    req[0] = 1'b0;
    repeat (10) step();
    chk("R5 pin", pin, 4'b0010);
    chk("R5 busy", busy, '0);

    // R6 restart with full delay
    tag = "R6";
    req[0] = 1'b1;
    step(); step(); step();
    req[0] = 1'b0;
    step();
    req[0] = 1'b1;
    wait_pin(0, 1'b1, 40, n);
    in_range("R6 latency", n, 6, 7);
    req[0] = 1'b0;
    wait_pin(0, 1'b0, 40, n);

    // R2 out-of-range index is ignored
    tag = "R2";
    cfg(4, 0, 0, 1);
    cfg(5, 9, 9, 1);
    step();
    chk("R2 pin", pin, 4'b0010);
    req[3] = 1'b1;
    step();
    chk("R2 line3 zero delay", pin, 4'b1010);
    req[3] = 1'b0;
    step();

    // R11 random mixed traffic
    tag = "R11";
    for (int k = 0; k < 3000; k++) begin
      if ($urandom_range(7) == 0) req[$urandom_range(LINES-1)] ^= 1'b1;
      if ($urandom_range(39) == 0)
        cfg($urandom_range(5), $urandom_range(5), $urandom_range(5), 1'($urandom_range(1)));
      else step();
    end
    req = '0;
    cfg(0, 0, 0, 0); cfg(1, 0, 0, 0); cfg(2, 0, 0, 0); cfg(3, 0, 0, 0);
    repeat (4) step();

    // R12 long rise delay
    tag = "R12";
    cfg(2, 70000, 0, 0);
    req[2] = 1'b1;
    wait_pin(2, 1'b1, 150000, n);
    in_range("R12 latency", n, 140000, 140001);

    $display("== %0d vectors applied, %0d miscompares ==", vecs, bad);
    $finish;
  end
endmodule